// File: doc/BRIEF.md
# Binary64 Result Rounder and Exception Packer

This block is the last stage of a double-precision arithmetic datapath. An upstream unit, such as a significand multiplier, delivers a result that is normalised but not yet rounded: a sign, a biased exponent held in a wider signed field that may fall outside the encodable range, a 53-bit significand whose leading bit is one, and guard and sticky bits. The block rounds this result under one of four modes and packs it into a 64-bit word. It also detects overflow, underflow and inexactness.

When a range trap is enabled, the block returns the rounded result with its exponent shifted back into the encodable range by a fixed amount and raises the matching trap cause. When no range trap is enabled, an overflowing result saturates to infinity or to the largest finite value, chosen by mode and sign. A result below the normal range is shifted into subnormal form and rounded a second time. Tininess is judged after rounding, by a trial round at exponent zero. One output register stage is present by default, and a parameter removes it.

Top module: `fp_round_pack`

## Requirements
- R1: The `rnd_mode` encoding is 00 to nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Nearest adds one ulp when guard is set and either sticky or the significand LSB is set. Toward zero never adds. Toward +infinity adds only to positive inexact results, and toward -infinity only to negative ones.
- R2: A rounding carry out of the 52-bit fraction clears the fraction and raises the exponent by one.
- R3: The first rounding is applied only to an inexact result whose exponent is above zero, or whose underflow trap is enabled.
- R4: A rounded exponent of 2047 or more with the overflow trap enabled gives the rounded fraction with the exponent lowered by 1536. It sets `out_trap[2]`, and no overflow flag.
- R5: An untrapped overflow sets the overflow flag and inexact. The result is infinity under nearest and under a directed mode pointing the result's own way. It is the largest finite magnitude under toward zero and under a directed mode pointing the other way.
- R6: An exponent of zero or less with the underflow trap enabled gives the rounded fraction with the exponent raised by 1536. It sets `out_trap[1]`, and no underflow flag.
- R7: At exponent exactly zero with an inexact input, the result is not tiny when a round under the current mode would carry into the normal range.
- R8: An untrapped tiny result is shifted right by one minus its exponent. The shifted-out bits form a new guard and sticky, and the result is rounded again under the current mode. A carry from that second round lands in the exponent field as one.
- R9: The underflow flag is set only for an untrapped result that is both tiny and inexact after denormalisation. An exact subnormal raises nothing.
- R10: Any inexact outcome sets `out_trap[0]` when the inexact trap is enabled, and otherwise sets the inexact flag. The two never occur together.
- R11: Outputs register one cycle after `in_valid` and hold while `in_valid` is low. `out_valid` follows `in_valid` by one cycle, and reset clears every output.
- R12: An exact result in the normal range is packed unchanged as sign, 11-bit exponent and 52-bit fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input result is present this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 14 | Signed biased exponent, possibly out of range |
| in_sig | input | 53 | Normalised significand, leading bit set |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| rnd_mode | input | 2 | Rounding mode, encoded as in R1 |
| trap_en_ovf | input | 1 | Overflow trap enable |
| trap_en_unf | input | 1 | Underflow trap enable |
| trap_en_inx | input | 1 | Inexact trap enable |
| out_valid | output | 1 | Output word is valid |
| out_result | output | 64 | Packed binary64 result |
| out_flag_ovf | output | 1 | Overflow flag |
| out_flag_unf | output | 1 | Underflow flag |
| out_flag_inx | output | 1 | Inexact flag |
| out_trap | output | 3 | Trap causes: bit 2 overflow, bit 1 underflow, bit 0 inexact |

## Verification
The hardest case to reach is an exponent of exactly zero paired with an all-ones significand. In that case the trial round, the denormalising shift and the second round all act on the same bits and can disagree about tininess. The stimulus drives the exponent port directly to zero and pairs the all-ones significand with guard and sticky combinations that make the trial round carry in one case and not in another. A third combination leaves the trial round without a carry while the second round still reaches the smallest normal number. Deep shifts past the whole significand are reached by driving exponents far below zero.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_TO_ZERO = 2'b01,
      RM_TO_POS  = 2'b10,
      RM_TO_NEG  = 2'b11
   } rmode_e;

   localparam int unsigned TRAP_INX = 0;
   localparam int unsigned TRAP_UNF = 1;
   localparam int unsigned TRAP_OVF = 2;
   localparam int unsigned TRAP_W   = 3;
endpackage

// File: rtl/fpr_round_dec.sv
// Decides whether one ulp is added, from mode, sign, LSB, guard and sticky.
module fpr_round_dec (
   input  logic [1:0] mode,
   input  logic       sign,
   input  logic       lsb,
   input  logic       guard,
   input  logic       sticky,
   output logic       bump
);
   import fpr_pkg::*;

   logic lost;
   assign lost = guard | sticky;

   always_comb begin
      case (rmode_e'(mode))
         RM_NEAREST: bump = guard & (sticky | lsb);
         RM_TO_ZERO: bump = 1'b0;
         RM_TO_POS:  bump = ~sign & lost;
         RM_TO_NEG:  bump = sign & lost;
         default:    bump = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpr_denorm.sv
// Right shift of significand plus guard; shifted-out bits fold into guard/sticky.
module fpr_denorm #(
   parameter int SIG_W = 53,
   parameter int SH_W  = 6
) (
   input  logic [SIG_W-1:0] sig,
   input  logic             guard,
   input  logic             sticky,
   input  logic [SH_W-1:0]  shamt,
   output logic [SIG_W-1:0] sig_o,
   output logic             guard_o,
   output logic             sticky_o
);
   localparam int LOW_W = SIG_W + 1;
   localparam int WIDE  = 2 * LOW_W;

   logic [WIDE-1:0] wide;
   logic [WIDE-1:0] moved;

   assign wide     = {sig, guard, {LOW_W{1'b0}}};
   assign moved    = wide >> shamt;
   assign sig_o    = moved[WIDE-1 -: SIG_W];
   assign guard_o  = moved[LOW_W];
   assign sticky_o = sticky | (|moved[LOW_W-1:0]);
endmodule

// File: rtl/fpr_sat_value.sv
// Magnitude returned on an untrapped overflow: infinity or largest finite.
module fpr_sat_value #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic                    sign,
   input  logic [1:0]              mode,
   output logic [EXP_W+FRAC_W-1:0] mag
);
   import fpr_pkg::*;

   logic to_inf;

   always_comb begin
      case (rmode_e'(mode))
         RM_NEAREST: to_inf = 1'b1;
         RM_TO_POS:  to_inf = ~sign;
         RM_TO_NEG:  to_inf = sign;
         default:    to_inf = 1'b0;
      endcase
      if (to_inf) mag = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else        mag = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
   end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
   parameter int EXP_W    = 11,
   parameter int FRAC_W   = 52,
   parameter int EXP_IN_W = 14,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic                              in_sign,
   input  logic signed [EXP_IN_W-1:0]        in_exp,
   input  logic [FRAC_W:0]                   in_sig,
   input  logic                              in_guard,
   input  logic                              in_sticky,
   input  logic [1:0]                        rnd_mode,
   input  logic                              trap_en_ovf,
   input  logic                              trap_en_unf,
   input  logic                              trap_en_inx,
   output logic                              out_valid,
   output logic [EXP_W+FRAC_W:0]             out_result,
   output logic                              out_flag_ovf,
   output logic                              out_flag_unf,
   output logic                              out_flag_inx,
   output logic [2:0]                        out_trap
);
   import fpr_pkg::*;

   localparam int SIG_W  = FRAC_W + 1;
   localparam int RES_W  = 1 + EXP_W + FRAC_W;
   localparam int SH_MAX = SIG_W + 1;
   localparam int SH_W   = $clog2(SH_MAX + 1);

   localparam logic signed [EXP_IN_W-1:0] ZERO_E = '0;
   localparam logic signed [EXP_IN_W-1:0] EMAX_E = EXP_IN_W'((1 << EXP_W) - 1);
   localparam logic [EXP_W-1:0]           WRAP_L = EXP_W'(3 << (EXP_W - 2));
   localparam logic [EXP_IN_W:0]          ONE_X  = (EXP_IN_W+1)'(1);
   localparam logic [EXP_IN_W:0]          CAP_X  = (EXP_IN_W+1)'(SH_MAX);
   localparam logic [SH_W-1:0]            CAP_S  = SH_W'(SH_MAX);

   // elaboration-time parameter checks
   if (EXP_W < 3) begin : g_bad_exp
      $error("fp_round_pack: EXP_W must be at least 3");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fp_round_pack: FRAC_W must be at least 2");
   end
   if (EXP_IN_W < EXP_W + 2) begin : g_bad_ein
      $error("fp_round_pack: EXP_IN_W must exceed EXP_W by two or more");
   end
   if (EXP_IN_W + 1 <= SH_W) begin : g_bad_sh
      $error("fp_round_pack: exponent field too narrow for the shift count");
   end

   // ---------------- first rounding ----------------
   logic              inexact0, gate_rnd, bump_raw, bump1, carry1;
   logic [FRAC_W-1:0] frac1;
   logic signed [EXP_IN_W-1:0] e1;

   assign inexact0 = in_guard | in_sticky;
   assign gate_rnd = inexact0 & ((in_exp > ZERO_E) | trap_en_unf);

   fpr_round_dec u_dec_main (
      .mode   (rnd_mode),
      .sign   (in_sign),
      .lsb    (in_sig[0]),
      .guard  (in_guard),
      .sticky (in_sticky),
      .bump   (bump_raw)
   );

   assign bump1           = gate_rnd & bump_raw;
   assign {carry1, frac1} = {1'b0, in_sig[FRAC_W-1:0]} + {{FRAC_W{1'b0}}, bump1};
   assign e1              = in_exp + $signed({{(EXP_IN_W-1){1'b0}}, carry1});

   // ---------------- range classification ----------------
   logic is_ovf, is_unf;
   logic [EXP_W-1:0] e_ovw, e_unw;

   assign is_ovf = (e1 >= EMAX_E);
   assign is_unf = ~(e1 > ZERO_E);
   assign e_ovw  = e1[EXP_W-1:0] - WRAP_L;
   assign e_unw  = e1[EXP_W-1:0] + WRAP_L;

   // tininess after rounding: trial round at exponent zero
   logic trial_carry, tiny;
   assign trial_carry = (e1 == ZERO_E) & inexact0 & bump_raw & (&in_sig[FRAC_W-1:0]);
   assign tiny        = ~trial_carry;

   // ---------------- denormalise and re-round ----------------
   logic [EXP_IN_W:0] sh_full;
   logic [SH_W-1:0]   shamt;
   logic [SIG_W-1:0]  d_sig, d_round;
   logic              d_g, d_s, inexact2, bump2;

   assign sh_full = ONE_X - {e1[EXP_IN_W-1], e1};
   assign shamt   = (sh_full > CAP_X) ? CAP_S : sh_full[SH_W-1:0];

   fpr_denorm #(.SIG_W(SIG_W), .SH_W(SH_W)) u_denorm (
      .sig      (in_sig),
      .guard    (in_guard),
      .sticky   (in_sticky),
      .shamt    (shamt),
      .sig_o    (d_sig),
      .guard_o  (d_g),
      .sticky_o (d_s)
   );

   fpr_round_dec u_dec_sub (
      .mode   (rnd_mode),
      .sign   (in_sign),
      .lsb    (d_sig[0]),
      .guard  (d_g),
      .sticky (d_s),
      .bump   (bump2)
   );

   assign inexact2 = d_g | d_s;
   assign d_round  = d_sig + {{(SIG_W-1){1'b0}}, bump2};

   // ---------------- saturation value ----------------
   logic [EXP_W+FRAC_W-1:0] sat_mag;

   fpr_sat_value #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sat (
      .sign (in_sign),
      .mode (rnd_mode),
      .mag  (sat_mag)
   );

   // ---------------- result and exception select ----------------
   logic [RES_W-1:0]  nx_res;
   logic              nx_ovf, nx_unf, nx_inx, inx_any;
   logic [TRAP_W-1:0] nx_trap;

   always_comb begin
      nx_res  = '0;
      nx_ovf  = 1'b0;
      nx_unf  = 1'b0;
      nx_inx  = 1'b0;
      nx_trap = '0;
      inx_any = 1'b0;
      if (is_ovf) begin
         if (trap_en_ovf) begin
            nx_res            = {in_sign, e_ovw, frac1};
            nx_trap[TRAP_OVF] = 1'b1;
            inx_any           = inexact0;
         end else begin
            nx_res  = {in_sign, sat_mag};
            nx_ovf  = 1'b1;
            inx_any = 1'b1;
         end
      end else if (is_unf) begin
         if (trap_en_unf) begin
            nx_res            = {in_sign, e_unw, frac1};
            nx_trap[TRAP_UNF] = 1'b1;
            inx_any           = inexact0;
         end else begin
            nx_res  = {in_sign, {(EXP_W-1){1'b0}}, d_round};
            inx_any = inexact2;
            nx_unf  = tiny & inexact2;
         end
      end else begin
         nx_res  = {in_sign, e1[EXP_W-1:0], frac1};
         inx_any = inexact0;
      end
      if (inx_any) begin
         if (trap_en_inx) nx_trap[TRAP_INX] = 1'b1;
         else             nx_inx            = 1'b1;
      end
   end

   // ---------------- output stage variant ----------------
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_flag_ovf <= 1'b0;
            out_flag_unf <= 1'b0;
            out_flag_inx <= 1'b0;
            out_trap     <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_result   <= nx_res;
               out_flag_ovf <= nx_ovf;
               out_flag_unf <= nx_unf;
               out_flag_inx <= nx_inx;
               out_trap     <= nx_trap;
            end
         end
      end
   end else begin : g_comb
      assign out_valid    = in_valid;
      assign out_result   = nx_res;
      assign out_flag_ovf = nx_ovf;
      assign out_flag_unf = nx_unf;
      assign out_flag_inx = nx_inx;
      assign out_trap     = nx_trap;
   end
endmodule

// File: rtl/fp_round_pack_chk.sv
module fp_round_pack_chk #(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter bit OUT_REG = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic [EXP_W+FRAC_W-1:0] res_body,
   input logic                    out_flag_ovf,
   input logic                    out_flag_unf,
   input logic                    out_flag_inx,
   input logic [2:0]              out_trap
);
   logic [EXP_W-1:0]  ex_f;
   logic [FRAC_W-1:0] fr_f;
   assign ex_f = res_body[EXP_W+FRAC_W-1 -: EXP_W];
   assign fr_f = res_body[FRAC_W-1:0];

   if (OUT_REG) begin : g_lat
      a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(in_valid) && $past(rst_n)) |-> out_valid);
      a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(in_valid));
   end else begin : g_nolat
      a_r11_valid_comb: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
   end

   a_r5_flag_or_trap: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_flag_ovf && out_trap[2]));
   a_r5_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_ovf) |-> (out_flag_inx || out_trap[0]));
   a_r5_sat_value: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_ovf) |->
         ((&ex_f && fr_f == '0) || (ex_f == {{(EXP_W-1){1'b1}}, 1'b0} && &fr_f)));
   a_r10_inx_excl: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_flag_inx && out_trap[0]));
   a_r9_unf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_unf) |-> (out_flag_inx || out_trap[0]));
   a_r9_unf_small: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_unf) |-> (ex_f <= EXP_W'(1)));
   a_r6_one_range_trap: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_trap[2] && out_trap[1]));
   a_r6_trap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_trap[1]) |-> !out_flag_unf);
endmodule

bind fp_round_pack fp_round_pack_chk #(
   .EXP_W   (EXP_W),
   .FRAC_W  (FRAC_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .out_valid    (out_valid),
   .res_body     (out_result[EXP_W+FRAC_W-1:0]),
   .out_flag_ovf (out_flag_ovf),
   .out_flag_unf (out_flag_unf),
   .out_flag_inx (out_flag_inx),
   .out_trap     (out_trap)
);

// File: tb/test_fp_round_pack.sv
`timescale 1ns/1ps
module test_fp_round_pack;
   localparam logic [52:0] H    = 53'h10_0000_0000_0000;
   localparam logic [52:0] ONES = 53'h1F_FFFF_FFFF_FFFF;
   localparam logic [1:0]  NEAR = 2'b00, RZ = 2'b01, RP = 2'b10, RN = 2'b11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_sign = 1'b0;
   logic signed [13:0] in_exp = '0;
   logic [52:0]       in_sig = '0;
   logic              in_guard = 1'b0, in_sticky = 1'b0;
   logic [1:0]        rnd_mode = 2'b00;
   logic              trap_en_ovf = 1'b0, trap_en_unf = 1'b0, trap_en_inx = 1'b0;
   logic              out_valid;
   logic [63:0]       out_result;
   logic              out_flag_ovf, out_flag_unf, out_flag_inx;
   logic [2:0]        out_trap;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   fp_round_pack i_fp_round_pack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard), .in_sticky(in_sticky),
      .rnd_mode(rnd_mode), .trap_en_ovf(trap_en_ovf), .trap_en_unf(trap_en_unf),
      .trap_en_inx(trap_en_inx), .out_valid(out_valid), .out_result(out_result),
      .out_flag_ovf(out_flag_ovf), .out_flag_unf(out_flag_unf),
      .out_flag_inx(out_flag_inx), .out_trap(out_trap)
   );

   // apply one input for one cycle; outputs are ready at the next falling edge
   task automatic run(input logic s, input int e, input logic [52:0] m,
                      input logic g, input logic st, input logic [1:0] rm,
                      input logic [2:0] ten);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = 14'(e); in_sig = m;
      in_guard = g; in_sticky = st; rnd_mode = rm;
      {trap_en_ovf, trap_en_unf, trap_en_inx} = ten;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // eflg = {ovf, unf, inx}; etrp = {ovf, unf, inx}
   task automatic check(input string tag, input logic [63:0] er,
                        input logic [2:0] eflg, input logic [2:0] etrp);
      logic [2:0] flg;
      flg = {out_flag_ovf, out_flag_unf, out_flag_inx};
      n_tests++;
      if (out_valid !== 1'b1 || out_result !== er || flg !== eflg || out_trap !== etrp) begin
         n_fail++;
         $display("FAIL %s: got v=%b res=%h flags=%b trap=%b, expected v=1 res=%h flags=%b trap=%b",
                  tag, out_valid, out_result, flg, out_trap, er, eflg, etrp);
      end
   endtask

   task automatic t_reset_and_hold();
      logic [63:0] held;
      n_tests++;
      if (out_valid !== 1'b0 || out_result !== 64'h0 || out_trap !== 3'b0 ||
          {out_flag_ovf, out_flag_unf, out_flag_inx} !== 3'b0) begin
         n_fail++;
         $display("FAIL R11 reset: got v=%b res=%h trap=%b, expected all zero",
                  out_valid, out_result, out_trap);
      end
      run(1'b0, 1023, H | 53'd9, 1'b0, 1'b0, NEAR, 3'b000);
      check("R11 one-cycle latency", 64'h3FF0_0000_0000_0009, 3'b000, 3'b000);
      held = out_result;
      in_exp = 14'd5; in_sig = ONES; in_guard = 1'b1;
      @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || out_result !== held) begin
         n_fail++;
         $display("FAIL R11 hold: got v=%b res=%h, expected v=0 res=%h", out_valid, out_result, held);
      end
   endtask

   task automatic t_exact_normal();
      run(1'b0, 1023, H | 53'd5, 1'b0, 1'b0, NEAR, 3'b000);
      check("R12 exact pack", 64'h3FF0_0000_0000_0005, 3'b000, 3'b000);
      run(1'b1, 1, H, 1'b0, 1'b0, RP, 3'b000);
      check("R12 smallest normal negative", 64'h8010_0000_0000_0000, 3'b000, 3'b000);
   endtask

   task automatic t_modes();
      run(1'b0, 1023, H | 53'd4, 1'b1, 1'b0, NEAR, 3'b000);
      check("R1 nearest tie even stays", 64'h3FF0_0000_0000_0004, 3'b001, 3'b000);
      run(1'b0, 1023, H | 53'd5, 1'b1, 1'b0, NEAR, 3'b000);
      check("R1 nearest tie odd rounds up", 64'h3FF0_0000_0000_0006, 3'b001, 3'b000);
      run(1'b0, 1023, H | 53'd4, 1'b1, 1'b1, NEAR, 3'b000);
      check("R1 nearest above half", 64'h3FF0_0000_0000_0005, 3'b001, 3'b000);
      run(1'b0, 1023, H | 53'd4, 1'b0, 1'b1, NEAR, 3'b000);
      check("R1 nearest below half", 64'h3FF0_0000_0000_0004, 3'b001, 3'b000);
      run(1'b0, 1023, H | 53'd4, 1'b1, 1'b1, RZ, 3'b000);
      check("R1 toward zero", 64'h3FF0_0000_0000_0004, 3'b001, 3'b000);
      run(1'b0, 1023, H | 53'd4, 1'b0, 1'b1, RP, 3'b000);
      check("R1 plus positive", 64'h3FF0_0000_0000_0005, 3'b001, 3'b000);
      run(1'b1, 1023, H | 53'd4, 1'b0, 1'b1, RP, 3'b000);
      check("R1 plus negative", 64'hBFF0_0000_0000_0004, 3'b001, 3'b000);
      run(1'b1, 1023, H | 53'd4, 1'b0, 1'b1, RN, 3'b000);
      check("R1 minus negative", 64'hBFF0_0000_0000_0005, 3'b001, 3'b000);
      run(1'b0, 1023, H | 53'd4, 1'b0, 1'b1, RN, 3'b000);
      check("R1 minus positive", 64'h3FF0_0000_0000_0004, 3'b001, 3'b000);
   endtask

   task automatic t_carry();
      run(1'b0, 1023, ONES, 1'b1, 1'b1, NEAR, 3'b000);
      check("R2 carry raises exponent", 64'h4000_0000_0000_0000, 3'b001, 3'b000);
   endtask

   task automatic t_overflow_untrapped();
      run(1'b0, 2046, ONES, 1'b0, 1'b0, NEAR, 3'b000);
      check("R5 boundary largest finite exact", 64'h7FEF_FFFF_FFFF_FFFF, 3'b000, 3'b000);
      run(1'b0, 2046, ONES, 1'b1, 1'b0, NEAR, 3'b000);
      check("R5 carry into overflow gives inf", 64'h7FF0_0000_0000_0000, 3'b101, 3'b000);
      run(1'b0, 2047, H, 1'b0, 1'b0, RZ, 3'b000);
      check("R5 toward zero gives max", 64'h7FEF_FFFF_FFFF_FFFF, 3'b101, 3'b000);
      run(1'b1, 2047, H, 1'b0, 1'b0, RP, 3'b000);
      check("R5 plus on negative gives -max", 64'hFFEF_FFFF_FFFF_FFFF, 3'b101, 3'b000);
      run(1'b1, 2047, H, 1'b0, 1'b0, RN, 3'b000);
      check("R5 minus on negative gives -inf", 64'hFFF0_0000_0000_0000, 3'b101, 3'b000);
      run(1'b0, 2047, H, 1'b0, 1'b0, RN, 3'b000);
      check("R5 minus on positive gives max", 64'h7FEF_FFFF_FFFF_FFFF, 3'b101, 3'b000);
   endtask

   task automatic t_overflow_trapped();
      run(1'b0, 2100, H | 53'd3, 1'b0, 1'b0, NEAR, 3'b100);
      check("R4 wrapped exact", 64'h2340_0000_0000_0003, 3'b000, 3'b100);
      run(1'b0, 2100, H | 53'd3, 1'b1, 1'b0, NEAR, 3'b100);
      check("R4 wrapped rounded with inexact flag", 64'h2340_0000_0000_0004, 3'b001, 3'b100);
      run(1'b0, 2100, H | 53'd3, 1'b1, 1'b0, NEAR, 3'b101);
      check("R4 wrapped with inexact trap", 64'h2340_0000_0000_0004, 3'b000, 3'b101);
   endtask

   task automatic t_underflow_trapped();
      run(1'b0, -5, H | 53'd3, 1'b1, 1'b1, NEAR, 3'b010);
      check("R6 R3 wrapped up and rounded", 64'h5FB0_0000_0000_0004, 3'b001, 3'b010);
      run(1'b0, 0, H, 1'b0, 1'b0, NEAR, 3'b010);
      check("R6 exponent zero exact", 64'h6000_0000_0000_0000, 3'b000, 3'b010);
   endtask

   task automatic t_tininess();
      run(1'b0, 0, ONES, 1'b1, 1'b0, NEAR, 3'b000);
      check("R7 trial carry means not tiny", 64'h0010_0000_0000_0000, 3'b001, 3'b000);
      run(1'b0, 0, ONES, 1'b1, 1'b0, RZ, 3'b000);
      check("R7 no trial carry means tiny", 64'h000F_FFFF_FFFF_FFFF, 3'b011, 3'b000);
      run(1'b0, 0, ONES, 1'b0, 1'b1, NEAR, 3'b000);
      check("R7 tiny yet rounds to min normal", 64'h0010_0000_0000_0000, 3'b011, 3'b000);
   endtask

   task automatic t_denorm();
      run(1'b0, -1, H | 53'd3, 1'b0, 1'b0, NEAR, 3'b000);
      check("R8 shift two and round up", 64'h0004_0000_0000_0001, 3'b011, 3'b000);
      run(1'b0, -1, H | 53'd3, 1'b0, 1'b0, RZ, 3'b000);
      check("R8 shift two toward zero", 64'h0004_0000_0000_0000, 3'b011, 3'b000);
      run(1'b0, -100, H, 1'b0, 1'b0, NEAR, 3'b000);
      check("R8 deep shift to zero", 64'h0000_0000_0000_0000, 3'b011, 3'b000);
      run(1'b0, -100, H, 1'b0, 1'b0, RP, 3'b000);
      check("R8 deep shift plus gives min subnormal", 64'h0000_0000_0000_0001, 3'b011, 3'b000);
      run(1'b1, -100, H, 1'b0, 1'b0, RN, 3'b000);
      check("R8 deep shift minus negative", 64'h8000_0000_0000_0001, 3'b011, 3'b000);
   endtask

   task automatic t_exact_tiny();
      run(1'b0, -1, H, 1'b0, 1'b0, NEAR, 3'b000);
      check("R9 exact subnormal raises nothing", 64'h0004_0000_0000_0000, 3'b000, 3'b000);
   endtask

   task automatic t_inexact_trap();
      run(1'b0, 1023, H | 53'd4, 1'b1, 1'b1, NEAR, 3'b001);
      check("R10 normal inexact trap", 64'h3FF0_0000_0000_0005, 3'b000, 3'b001);
      run(1'b0, -1, H | 53'd3, 1'b0, 1'b0, NEAR, 3'b001);
      check("R10 tiny inexact trap", 64'h0004_0000_0000_0001, 3'b010, 3'b001);
      run(1'b0, 2047, H, 1'b0, 1'b0, NEAR, 3'b001);
      check("R10 untrapped overflow inexact trap", 64'h7FF0_0000_0000_0000, 3'b100, 3'b001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_and_hold();
      t_exact_normal();
      t_modes();
      t_carry();
      t_overflow_untrapped();
      t_overflow_trapped();
      t_underflow_trapped();
      t_tininess();
      t_denorm();
      t_exact_tiny();
      t_inexact_trap();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R11 watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule